// File: doc/BRIEF.md
# Special-Group Function Decode and Retire Stage

This block is the decode-and-retire slice of a small MIPS-style core for instructions whose primary opcode is zero, the "special" group. It reads the 6-bit function field and sorts the instruction into one of these classes: system call, register jump, register jump-and-link, register ALU operation, HI/LO move or multiply/divide, or a no-effect instruction. The no-effect class is an explicit allow-list. It holds the memory barrier (function 0x0F) and a short parameterised list of whole 32-bit words that are accepted only on an exact match. Instructions outside the special group are passed on as ordinary work, with their register-write and memory-request intent flagged.

Each accepted instruction retires one clock later. The stage gives a retire pulse, the PC of the retired instruction, its class and its side-effect flags, and it advances the fetch PC by 4. It does not compute jump targets, and it has no ALU datapath or memory stage. A special-group instruction whose function code is not allocated has two possible outcomes. With strict mode on, it traps: the faulting PC and word are captured and retirement stops until reset. With strict mode off, it retires with no architectural effect.

Top module: `spec_decode_retire`

## Requirements
- R1: While reset is held and on the first cycle after it is released, fetch_pc equals RESET_PC (default 0x00100000), retire_vld is 0, retire_count is 0 and trap_flag is 0.
- R2: The barrier word 0x0000000F (opcode 0, function 0x0F) retires with retire_class 6 (no-effect), and retire_rf_we, retire_hilo_we and retire_mem_req are all 0.
- R3: An instruction accepted on a clock edge is retired in the next cycle. retire_vld is high for one cycle, retire_pc equals the fetch_pc at acceptance, and fetch_pc has advanced by 4.
- R4: A word that exactly matches an entry of EXACT_WORDS (defaults 0x42000038 and 0x42000039) retires as class 6 with no side effects. A word that differs from every entry is classified by its opcode: 0x4200003A retires as class 0 with no flags set.
- R5: Special-group function codes map to classes as follows. 0x0C is class 1. 0x08 is class 2. 0x09 is class 3 with rf_we. Functions 0x00, 0x02, 0x03, 0x04, 0x06, 0x07, 0x20–0x27, 0x2A and 0x2B are class 4 with rf_we. Functions 0x10 and 0x12 are class 5 with rf_we. Functions 0x11, 0x13 and 0x18–0x1B are class 5 with hilo_we.
- R6: With strict_en high, a special-group word whose function code is listed in neither R2 nor R5 (for example 0x0000000E) does not retire. In the next cycle trap_flag is 1, trap_pc holds the faulting fetch_pc and trap_word holds the word.
- R7: With strict_en low, such a word retires as class 7 with all three side-effect flags at 0.
- R8: Once trap_flag is set, no instruction retires, and fetch_pc, trap_pc and trap_word hold their values until reset.
- R9: retire_count increases by exactly one for each retire and does not count the trapping instruction.
- R10: Non-special instructions retire as class 0. Opcodes 0x08–0x0F and 0x20–0x27 set rf_we, and opcodes 0x20–0x2F set mem_req. A LUI (opcode 0x0F) followed by an ORI (opcode 0x0D) after a barrier both retire with rf_we.
- R11: In a cycle where instr_valid is low, nothing retires and fetch_pc holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strict_en | input | 1 | Trap on unallocated special-group function codes |
| instr_valid | input | 1 | instr_word holds the instruction at fetch_pc |
| instr_word | input | 32 | Instruction word |
| fetch_pc | output | PC_W | PC of the next instruction to accept |
| retire_vld | output | 1 | One-cycle retire pulse |
| retire_pc | output | PC_W | PC of the retired instruction |
| retire_class | output | 3 | Class code of the retired instruction |
| retire_rf_we | output | 1 | Retired instruction writes a general register |
| retire_hilo_we | output | 1 | Retired instruction writes HI/LO |
| retire_mem_req | output | 1 | Retired instruction accesses memory |
| retire_count | output | CNT_W | Number of retired instructions |
| trap_flag | output | 1 | Strict-mode trap taken |
| trap_pc | output | PC_W | PC of the trapping instruction |
| trap_word | output | 32 | Word of the trapping instruction |

## Verification
The bench places unallocated function 0x0E directly beside the barrier. A decoder that matches on a range instead of exact codes would then retire 0x0E quietly in strict mode instead of trapping. It also sends a word one bit away from an exact-match entry, which a field-only match would wrongly accept as no-effect. After a trap it keeps presenting valid instructions to catch a design that resumes retiring, advances the PC or counts the trapped word. It toggles strict mode to expose a lenient path that still traps or that leaks a register-write flag.

// File: rtl/spec_pkg.sv
package spec_pkg;

  localparam int INSN_W = 32;

  typedef enum logic [2:0] {
    CLS_OTHER   = 3'd0,
    CLS_SYSCALL = 3'd1,
    CLS_JR      = 3'd2,
    CLS_JALR    = 3'd3,
    CLS_ALU     = 3'd4,
    CLS_HILO    = 3'd5,
    CLS_NOEFF   = 3'd6,
    CLS_UNKNOWN = 3'd7
  } insn_class_e;

  typedef struct packed {
    insn_class_e cls;
    logic        rf_we;
    logic        hilo_we;
    logic        mem_req;
    logic        illegal;
  } dec_info_t;

  localparam logic [5:0] FN_JR      = 6'h08;
  localparam logic [5:0] FN_JALR    = 6'h09;
  localparam logic [5:0] FN_SYSCALL = 6'h0C;
  localparam logic [5:0] FN_BARRIER = 6'h0F;

endpackage

// File: rtl/spec_funct_classifier.sv
module spec_funct_classifier
  import spec_pkg::*;
#(
  parameter int                       N_EXACT     = 2,
  parameter logic [N_EXACT*INSN_W-1:0] EXACT_WORDS = {32'h4200_0039, 32'h4200_0038}
) (
  input  logic [INSN_W-1:0] word,
  output dec_info_t         info
);

  logic [5:0]         opc;
  logic [5:0]         fn;
  logic [N_EXACT-1:0] exact_hit;

  assign opc = word[31:26];
  assign fn  = word[5:0];

  genvar gi;
  generate
    for (gi = 0; gi < N_EXACT; gi++) begin : g_exact
      assign exact_hit[gi] = (word == EXACT_WORDS[gi*INSN_W +: INSN_W]);
    end
  endgenerate

  always_comb begin
    info = '{cls: CLS_OTHER, rf_we: 1'b0, hilo_we: 1'b0, mem_req: 1'b0, illegal: 1'b0};
    if (|exact_hit) begin
      info.cls = CLS_NOEFF;
    end else if (opc != 6'h00) begin
      info.cls     = CLS_OTHER;
      info.rf_we   = (opc[5:3] == 3'b001) || (opc[5:3] == 3'b100);
      info.mem_req = (opc[5:4] == 2'b10);
    end else begin
      case (fn)
        FN_SYSCALL: info.cls = CLS_SYSCALL;
        FN_JR:      info.cls = CLS_JR;
        FN_JALR: begin
          info.cls   = CLS_JALR;
          info.rf_we = 1'b1;
        end
        FN_BARRIER: info.cls = CLS_NOEFF;
        6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07,
        6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27,
        6'h2A, 6'h2B: begin
          info.cls   = CLS_ALU;
          info.rf_we = 1'b1;
        end
        6'h10, 6'h12: begin
          info.cls   = CLS_HILO;
          info.rf_we = 1'b1;
        end
        6'h11, 6'h13, 6'h18, 6'h19, 6'h1A, 6'h1B: begin
          info.cls     = CLS_HILO;
          info.hilo_we = 1'b1;
        end
        default: begin
          info.cls     = CLS_UNKNOWN;
          info.illegal = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/spec_retire_unit.sv
module spec_retire_unit
  import spec_pkg::*;
#(
  parameter int             PC_W     = 32,
  parameter int             CNT_W    = 16,
  parameter logic [PC_W-1:0] RESET_PC = 32'h0010_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  dec_info_t        info,
  output logic [PC_W-1:0]  pc_q,
  output logic             vld_q,
  output logic [PC_W-1:0]  rpc_q,
  output insn_class_e      cls_q,
  output logic             rf_q,
  output logic             hilo_q,
  output logic             mem_q,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= RESET_PC;
      vld_q  <= 1'b0;
      rpc_q  <= '0;
      cls_q  <= CLS_OTHER;
      rf_q   <= 1'b0;
      hilo_q <= 1'b0;
      mem_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      vld_q <= accept;
      if (accept) begin
        rpc_q  <= pc_q;
        pc_q   <= pc_q + PC_STEP;
        cnt_q  <= cnt_q + 1'b1;
        cls_q  <= info.cls;
        rf_q   <= info.rf_we;
        hilo_q <= info.hilo_we;
        mem_q  <= info.mem_req;
      end
    end
  end

endmodule

// File: rtl/spec_trap_capture.sv
module spec_trap_capture
  import spec_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [PC_W-1:0]   pc,
  input  logic [INSN_W-1:0] word,
  output logic              flag_q,
  output logic [PC_W-1:0]   pc_q,
  output logic [INSN_W-1:0] word_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      pc_q   <= '0;
      word_q <= '0;
    end else if (take && !flag_q) begin
      flag_q <= 1'b1;
      pc_q   <= pc;
      word_q <= word;
    end
  end

endmodule

// File: rtl/spec_decode_retire.sv
module spec_decode_retire
  import spec_pkg::*;
#(
  parameter int                        PC_W        = 32,
  parameter int                        CNT_W       = 16,
  parameter logic [PC_W-1:0]           RESET_PC    = 32'h0010_0000,
  parameter int                        N_EXACT     = 2,
  parameter logic [N_EXACT*INSN_W-1:0] EXACT_WORDS = {32'h4200_0039, 32'h4200_0038}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strict_en,
  input  logic             instr_valid,
  input  logic [31:0]      instr_word,
  output logic [PC_W-1:0]  fetch_pc,
  output logic             retire_vld,
  output logic [PC_W-1:0]  retire_pc,
  output logic [2:0]       retire_class,
  output logic             retire_rf_we,
  output logic             retire_hilo_we,
  output logic             retire_mem_req,
  output logic [CNT_W-1:0] retire_count,
  output logic             trap_flag,
  output logic [PC_W-1:0]  trap_pc,
  output logic [31:0]      trap_word
);

  dec_info_t   dec;
  insn_class_e cls_r;
  logic        live;
  logic        take_trap;
  logic        accept;

  spec_funct_classifier #(
    .N_EXACT    (N_EXACT),
    .EXACT_WORDS(EXACT_WORDS)
  ) u_cls (
    .word(instr_word),
    .info(dec)
  );

  assign live      = instr_valid && !trap_flag;
  assign take_trap = live && strict_en && dec.illegal;
  assign accept    = live && !take_trap;

  spec_retire_unit #(
    .PC_W    (PC_W),
    .CNT_W   (CNT_W),
    .RESET_PC(RESET_PC)
  ) u_ret (
    .clk   (clk),
    .rst   (rst),
    .accept(accept),
    .info  (dec),
    .pc_q  (fetch_pc),
    .vld_q (retire_vld),
    .rpc_q (retire_pc),
    .cls_q (cls_r),
    .rf_q  (retire_rf_we),
    .hilo_q(retire_hilo_we),
    .mem_q (retire_mem_req),
    .cnt_q (retire_count)
  );

  assign retire_class = cls_r;

  spec_trap_capture #(
    .PC_W(PC_W)
  ) u_trap (
    .clk   (clk),
    .rst   (rst),
    .take  (take_trap),
    .pc    (fetch_pc),
    .word  (instr_word),
    .flag_q(trap_flag),
    .pc_q  (trap_pc),
    .word_q(trap_word)
  );

endmodule

// File: rtl/spec_decode_retire_chk.sv
module spec_decode_retire_chk #(
  parameter int PC_W  = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             instr_valid,
  input logic [PC_W-1:0]  fetch_pc,
  input logic             retire_vld,
  input logic [PC_W-1:0]  retire_pc,
  input logic [2:0]       retire_class,
  input logic             retire_rf_we,
  input logic             retire_hilo_we,
  input logic             retire_mem_req,
  input logic [CNT_W-1:0] retire_count,
  input logic             trap_flag,
  input logic [PC_W-1:0]  trap_pc,
  input logic [31:0]      trap_word
);

  p_quiet_noeff_r2: assert property (@(posedge clk) disable iff (rst)
    retire_vld && (retire_class == 3'd6) |-> !retire_rf_we && !retire_hilo_we && !retire_mem_req);

  p_quiet_lenient_r7: assert property (@(posedge clk) disable iff (rst)
    retire_vld && (retire_class == 3'd7) |-> !retire_rf_we && !retire_hilo_we && !retire_mem_req);

  p_pc_step_r3: assert property (@(posedge clk) disable iff (rst)
    retire_vld |-> fetch_pc == retire_pc + PC_W'(4));

  p_trap_entry_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(trap_flag) |-> !retire_vld && $stable(fetch_pc));

  p_trap_hold_r8: assert property (@(posedge clk) disable iff (rst)
    trap_flag |=> trap_flag && !retire_vld && $stable(trap_pc) && $stable(trap_word) && $stable(fetch_pc));

  p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
    retire_vld |-> retire_count == CNT_W'($past(retire_count) + 1'b1));

  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(instr_valid) |-> !retire_vld && $stable(fetch_pc));

endmodule

bind spec_decode_retire spec_decode_retire_chk #(
  .PC_W (PC_W),
  .CNT_W(CNT_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .instr_valid   (instr_valid),
  .fetch_pc      (fetch_pc),
  .retire_vld    (retire_vld),
  .retire_pc     (retire_pc),
  .retire_class  (retire_class),
  .retire_rf_we  (retire_rf_we),
  .retire_hilo_we(retire_hilo_we),
  .retire_mem_req(retire_mem_req),
  .retire_count  (retire_count),
  .trap_flag     (trap_flag),
  .trap_pc       (trap_pc),
  .trap_word     (trap_word)
);

// File: tb/spec_decode_retire_bench.sv
`timescale 1ns/1ps
module spec_decode_retire_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strict_en = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic [31:0] fetch_pc, retire_pc, trap_pc, trap_word;
  logic        retire_vld, retire_rf_we, retire_hilo_we, retire_mem_req, trap_flag;
  logic [2:0]  retire_class;
  logic [15:0] retire_count;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spec_decode_retire u_spec_decode_retire (
    .clk(clk), .rst(rst), .strict_en(strict_en), .instr_valid(instr_valid),
    .instr_word(instr_word), .fetch_pc(fetch_pc), .retire_vld(retire_vld),
    .retire_pc(retire_pc), .retire_class(retire_class), .retire_rf_we(retire_rf_we),
    .retire_hilo_we(retire_hilo_we), .retire_mem_req(retire_mem_req),
    .retire_count(retire_count), .trap_flag(trap_flag), .trap_pc(trap_pc),
    .trap_word(trap_word)
  );

  // reference model state
  longint m_pc, m_cnt, m_rpc, m_tpc, m_tword;
  int     m_cls;
  bit     m_rv, m_rf, m_hl, m_mm, m_trap;
  int     alu_fn[$]  = '{0, 2, 3, 4, 6, 7, 32, 33, 34, 35, 36, 37, 38, 39, 42, 43};
  int     hrf_fn[$]  = '{16, 18};
  int     hhl_fn[$]  = '{17, 19, 24, 25, 26, 27};
  longint exact[$]   = '{64'h4200_0038, 64'h4200_0039};

  function automatic bit in_list(int v, int q[$]);
    foreach (q[i]) if (q[i] == v) return 1;
    return 0;
  endfunction

  function automatic void ref_decode(input logic [31:0] w, output int cls,
                                     output bit rf, output bit hl, output bit mm, output bit bad);
    int op = int'(w[31:26]);
    int fn = int'(w[5:0]);
    cls = 0; rf = 0; hl = 0; mm = 0; bad = 0;
    foreach (exact[i]) if (longint'(w) == exact[i]) begin cls = 6; return; end
    if (op != 0) begin
      rf = (op >= 8 && op <= 15) || (op >= 32 && op <= 39);
      mm = (op >= 32 && op <= 47);
    end else if (fn == 12) cls = 1;
    else if (fn == 8) cls = 2;
    else if (fn == 9) begin cls = 3; rf = 1; end
    else if (fn == 15) cls = 6;
    else if (in_list(fn, alu_fn)) begin cls = 4; rf = 1; end
    else if (in_list(fn, hrf_fn)) begin cls = 5; rf = 1; end
    else if (in_list(fn, hhl_fn)) begin cls = 5; hl = 1; end
    else begin cls = 7; bad = 1; end
  endfunction

  task automatic model_reset();
    m_pc = 64'h0010_0000; m_cnt = 0; m_rv = 0; m_trap = 0; m_tpc = 0; m_tword = 0;
    m_rpc = 0; m_cls = 0; m_rf = 0; m_hl = 0; m_mm = 0;
  endtask

  task automatic model_step(bit v, logic [31:0] w, bit strict);
    int c; bit rf, hl, mm, bad;
    m_rv = 0;
    if (v && !m_trap) begin
      ref_decode(w, c, rf, hl, mm, bad);
      if (bad && strict) begin
        m_trap = 1; m_tpc = m_pc; m_tword = longint'(w);
      end else begin
        m_rv = 1; m_rpc = m_pc; m_pc = m_pc + 4; m_cnt = m_cnt + 1;
        m_cls = c; m_rf = rf; m_hl = hl; m_mm = mm;
      end
    end
  endtask

  task automatic chk(string tag, string field, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, field, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk("R3", {tag, " fetch_pc"}, longint'(fetch_pc), m_pc);
    chk("R3", {tag, " retire_vld"}, longint'(retire_vld), longint'(m_rv));
    chk("R9", {tag, " retire_count"}, longint'(retire_count), m_cnt);
    chk(tag, "trap_flag", longint'(trap_flag), longint'(m_trap));
    if (m_trap) begin
      chk(tag, "trap_pc", longint'(trap_pc), m_tpc);
      chk(tag, "trap_word", longint'(trap_word), m_tword);
    end
    if (m_rv) begin
      chk("R3", {tag, " retire_pc"}, longint'(retire_pc), m_rpc);
      chk(tag, "retire_class", longint'(retire_class), longint'(m_cls));
      chk(tag, "rf_we", longint'(retire_rf_we), longint'(m_rf));
      chk(tag, "hilo_we", longint'(retire_hilo_we), longint'(m_hl));
      chk(tag, "mem_req", longint'(retire_mem_req), longint'(m_mm));
    end
  endtask

  task automatic cyc(bit v, logic [31:0] w, string tag);
    instr_valid = v;
    instr_word  = w;
    @(posedge clk);
    model_step(v, w, strict_en);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; instr_valid = 1'b0; instr_word = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    model_reset();
    compare("R1");
    rst = 1'b0;
    cyc(0, 32'h0, "R1");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // barrier then constant build
    cyc(1, 32'h0000_000F, "R2");
    cyc(1, 32'h3C08_1234, "R10");
    cyc(1, 32'h3508_5678, "R10");
    cyc(0, 32'h0000_000F, "R11");
    cyc(0, 32'h0000_000F, "R11");
    // special classes
    cyc(1, 32'h0000_000C, "R5");
    cyc(1, 32'h03E0_0008, "R5");
    cyc(1, 32'h0100_F809, "R5");
    cyc(1, 32'h0109_5021, "R5");
    cyc(1, 32'h0000_0000, "R5");
    cyc(1, 32'h0000_5010, "R5");
    cyc(1, 32'h0100_0013, "R5");
    cyc(1, 32'h0109_0018, "R5");
    cyc(1, 32'h0109_502B, "R5");
    // exact words and neighbours
    cyc(1, 32'h4200_0038, "R4");
    cyc(1, 32'h4200_0039, "R4");
    cyc(1, 32'h4200_003A, "R4");
    cyc(1, 32'h8C08_0000, "R10");
    cyc(1, 32'hAC08_0000, "R10");
    // lenient mode
    strict_en = 1'b0;
    cyc(1, 32'h0000_000E, "R7");
    cyc(1, 32'h0000_003F, "R7");
    cyc(1, 32'h0000_0005, "R7");
    // strict mode: barrier, then trap on its neighbour
    strict_en = 1'b1;
    cyc(1, 32'h0000_000F, "R2");
    cyc(1, 32'h0000_000E, "R6");
    for (int i = 0; i < 4; i++) cyc(1, 32'h3C08_0001, "R8");
    cyc(1, 32'h0000_000F, "R8");
    strict_en = 1'b0;
    cyc(1, 32'h0000_000E, "R8");
    // second run after reset
    strict_en = 1'b1;
    do_reset();
    for (int i = 0; i < 3; i++) cyc(1, 32'h0109_5021, "R9");
    cyc(1, 32'h0000_0005, "R6");
    cyc(1, 32'h0000_000C, "R8");
    cyc(0, 32'h0, "R8");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule